// File: doc/BRIEF.md
# Power Mode Sequencer with Write-Once Permissions

This block tracks which power mode a system is in and sequences moves between modes. There are seven modes: normal run, low-power run, low-power wait, normal stop, low-power stop, leakage-reduced stop and deep stop. Deep stop has four submodes.

Software reaches the block through a byte-wide register bus with four locations:
- A permission byte that may be written only once.
- A control byte that selects the run mode, the stop mode and the wake policy.
- A deep-stop byte that picks the submode and a brown-out option.
- A read-only one-hot status byte.

Handshake inputs from the processor drive the sequencing:
- A sleep request, qualified by a deep-sleep flag.
- An interrupt.
- A reset-during-entry indication.
- A debug-enable level.

Stop entry takes a fixed number of cycles. An interrupt or reset in that window cancels the entry and raises a sticky abort flag. Power switching, clock gating and regulators are outside the block; the mode is presented only as the one-hot status output.

Top module: `pwrModeCtl`

## Requirements
- R1: After reset the permission byte (offset 0) reads 0x00, control (offset 1) reads 0x00, deep-stop (offset 2) reads 0x03, status (offset 3) reads 0x01, and the abort output is low.
- R2: The first write to offset 0 after reset stores only bits 5 (low-power modes allowed), 3 (leakage-reduced stop allowed) and 1 (deep stop allowed). Every later write to offset 0 is ignored.
- R3: Control layout is as follows: bits 2:0 stop select, bit 3 read-only abort flag, bits 6:5 run select, bit 7 wake-to-run enable. Stop select takes 000 (normal), 010 (low-power, needs bit 5), 011 (leakage-reduced, needs bit 3) or 100 (deep, needs bit 1). A reserved code or a code without permission leaves the field unchanged.
- R4: Run select 10 (low-power run) is accepted only with bit 5 permitted and status showing normal run. Run select 00 is accepted only while status shows low-power run. Codes 01 and 11 are ignored. The mode follows the field one cycle after the write.
- R5: At offset 2, bits 2:0 take submodes 000 to 011, and values 100 to 111 leave them unchanged. Bit 5 (brown-out detect off in submode 0) is always stored.
- R6: Status is one-hot. Bit 0 is normal run, 1 normal stop, 2 low-power run, 3 low-power wait, 4 low-power stop, 5 leakage-reduced stop, 6 deep stop. Writes to offset 3 are ignored.
- R7: A sleep request with deep-sleep from normal or low-power run clears the abort flag on that edge. It enters the selected stop mode two cycles later. Normal stop selected from low-power run enters low-power stop.
- R8: An interrupt or entry reset during the entry window sets the abort flag and leaves the mode unchanged.
- R9: An interrupt in a stop mode returns to the run mode the entry started from. Low-power stop entered from normal run always returns to normal run.
- R10: With wake-to-run set, an interrupt in low-power run, wait or stop goes to normal run and clears run select to 00. Wake-to-run can be changed only while status shows normal run.
- R11: A sleep request without deep-sleep in low-power run enters low-power wait. An interrupt there returns to low-power run when wake-to-run is clear.
- R12: While debug is enabled, status does not change to normal stop or low-power stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the addressed register |
| sleepReq | input | 1 | Processor sleep request pulse |
| deepSleep | input | 1 | Qualifies a sleep request as a stop request |
| intReq | input | 1 | Pending interrupt |
| entryRst | input | 1 | Reset arriving during stop entry |
| dbgEn | input | 1 | Debug enabled |
| modeOneHot | output | 7 | One-hot current mode status |
| stopAborted | output | 1 | Last stop entry was aborted |

## Verification
The bench builds the block with its default parameters: a two-cycle entry window, a byte-wide bus and a two-bit offset. The two-cycle window lets the bench place an interrupt on the first entry cycle and an entry reset on the second, which reaches both abort points. Directed sequences cover every run, wait and stop path, with and without wake-to-run and debug. Seeded random writes to the deep-stop byte and to the stop-select and wake fields are compared against bench models of the field acceptance rules.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int MODE_N = 7;

  typedef enum logic [2:0] {
    RUN_NORMAL   = 3'd0,
    STOP_NORMAL  = 3'd1,
    RUN_LOWPWR   = 3'd2,
    WAIT_LOWPWR  = 3'd3,
    STOP_LOWPWR  = 3'd4,
    STOP_LOWLEAK = 3'd5,
    STOP_DEEP    = 3'd6
  } pmMode_e;

  localparam int PERM_LP_BIT   = 5;
  localparam int PERM_LL_BIT   = 3;
  localparam int PERM_DEEP_BIT = 1;

  localparam logic [2:0] STOPSEL_NORMAL  = 3'b000;
  localparam logic [2:0] STOPSEL_LOWPWR  = 3'b010;
  localparam logic [2:0] STOPSEL_LOWLEAK = 3'b011;
  localparam logic [2:0] STOPSEL_DEEP    = 3'b100;

  localparam logic [1:0] RUNSEL_NORMAL = 2'b00;
  localparam logic [1:0] RUNSEL_LOWPWR = 2'b10;

  typedef struct packed {
    logic clrAbort;
    logic setAbort;
    logic clrRunSel;
  } seqStrobe_t;

  function automatic logic [MODE_N-1:0] modeBits(pmMode_e m);
    return MODE_N'(1) << m;
  endfunction

endpackage

// File: rtl/pmcRegs.sv
module pmcRegs
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  seqStrobe_t        strb,
  input  logic [MODE_N-1:0] statusWord,
  output logic              permLp,
  output logic              permLl,
  output logic              permDeep,
  output logic [2:0]        stopSel,
  output logic [1:0]        runSel,
  output logic              wakeToRun,
  output logic              abortFlag
);

  localparam logic [ADDR_W-1:0] ADDR_PERM   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_DEEP   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(3);
  localparam logic [7:0] PERM_MASK =
    (8'd1 << PERM_LP_BIT) | (8'd1 << PERM_LL_BIT) | (8'd1 << PERM_DEEP_BIT);
  localparam logic [2:0] DEEP_SUB_RESET = 3'b011;

  logic [7:0] permReg;
  logic       permLocked;
  logic [2:0] deepSub;
  logic       porOff;
  logic       stopOk;
  logic       runOk;
  logic [2:0] wStop;
  logic [1:0] wRun;
  logic       statusIsRun;
  logic       statusIsLpRun;

  assign permLp        = permReg[PERM_LP_BIT];
  assign permLl        = permReg[PERM_LL_BIT];
  assign permDeep      = permReg[PERM_DEEP_BIT];
  assign wStop         = busWdata[2:0];
  assign wRun          = busWdata[6:5];
  assign statusIsRun   = statusWord[RUN_NORMAL];
  assign statusIsLpRun = statusWord[RUN_LOWPWR];

  always_comb begin
    case (wStop)
      STOPSEL_NORMAL:  stopOk = 1'b1;
      STOPSEL_LOWPWR:  stopOk = permLp;
      STOPSEL_LOWLEAK: stopOk = permLl;
      STOPSEL_DEEP:    stopOk = permDeep;
      default:         stopOk = 1'b0;
    endcase
  end

  always_comb begin
    case (wRun)
      RUNSEL_LOWPWR: runOk = permLp && statusIsRun;
      RUNSEL_NORMAL: runOk = (runSel == RUNSEL_NORMAL) || statusIsLpRun;
      default:       runOk = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      permReg    <= '0;
      permLocked <= 1'b0;
      stopSel    <= STOPSEL_NORMAL;
      runSel     <= RUNSEL_NORMAL;
      wakeToRun  <= 1'b0;
      abortFlag  <= 1'b0;
      deepSub    <= DEEP_SUB_RESET;
      porOff     <= 1'b0;
    end else begin
      if (strb.clrAbort) abortFlag <= 1'b0;
      if (strb.setAbort) abortFlag <= 1'b1;
      if (strb.clrRunSel) runSel <= RUNSEL_NORMAL;
      if (busWr) begin
        case (busAddr)
          ADDR_PERM: begin
            if (!permLocked) begin
              permReg    <= busWdata[7:0] & PERM_MASK;
              permLocked <= 1'b1;
              stopSel    <= STOPSEL_NORMAL;
            end
          end
          ADDR_CTRL: begin
            if (stopOk) stopSel <= wStop;
            if (runOk && !strb.clrRunSel) runSel <= wRun;
            if (statusIsRun) wakeToRun <= busWdata[7];
          end
          ADDR_DEEP: begin
            if (!busWdata[2]) deepSub <= busWdata[2:0];
            porOff <= busWdata[5];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_PERM:   busRdata = DATA_W'(permReg);
      ADDR_CTRL:   busRdata = DATA_W'({wakeToRun, runSel, 1'b0, abortFlag, stopSel});
      ADDR_DEEP:   busRdata = DATA_W'({2'b00, porOff, 2'b00, deepSub});
      ADDR_STATUS: busRdata = DATA_W'({1'b0, statusWord});
      default:     busRdata = '0;
    endcase
  end

endmodule

// File: rtl/pmcSeq.sv
module pmcSeq
  import pmc_pkg::*;
#(
  parameter int ENTRY_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepReq,
  input  logic              deepSleep,
  input  logic              intReq,
  input  logic              entryRst,
  input  logic              dbgEn,
  input  logic [2:0]        stopSel,
  input  logic [1:0]        runSel,
  input  logic              wakeToRun,
  output seqStrobe_t        strb,
  output logic [MODE_N-1:0] statusWord,
  output logic              inEntry
);

  localparam int CNT_W = $clog2(ENTRY_CYC + 1);

  pmMode_e    curMode;
  pmMode_e    nxtMode;
  pmMode_e    target;
  logic       fromLp;
  logic       entering;
  logic [CNT_W-1:0] cnt;
  logic       startEntry;
  logic       abortNow;

  assign inEntry = entering;

  function automatic pmMode_e stopTarget(logic [2:0] sel, logic lp);
    case (sel)
      STOPSEL_NORMAL:  return lp ? STOP_LOWPWR : STOP_NORMAL;
      STOPSEL_LOWPWR:  return STOP_LOWPWR;
      STOPSEL_LOWLEAK: return STOP_LOWLEAK;
      default:         return STOP_DEEP;
    endcase
  endfunction

  always_comb begin
    nxtMode    = curMode;
    strb       = '0;
    startEntry = 1'b0;
    abortNow   = 1'b0;
    if (entering) begin
      if (intReq || entryRst) begin
        abortNow      = 1'b1;
        strb.setAbort = 1'b1;
      end else if (cnt == CNT_W'(1)) begin
        nxtMode = target;
      end
    end else begin
      case (curMode)
        RUN_NORMAL: begin
          if (runSel == RUNSEL_LOWPWR) nxtMode = RUN_LOWPWR;
          else if (sleepReq && deepSleep) begin
            startEntry    = 1'b1;
            strb.clrAbort = 1'b1;
          end
        end
        RUN_LOWPWR: begin
          if (intReq && wakeToRun) begin
            nxtMode        = RUN_NORMAL;
            strb.clrRunSel = 1'b1;
          end else if (runSel == RUNSEL_NORMAL) begin
            nxtMode = RUN_NORMAL;
          end else if (sleepReq) begin
            if (deepSleep) begin
              startEntry    = 1'b1;
              strb.clrAbort = 1'b1;
            end else begin
              nxtMode = WAIT_LOWPWR;
            end
          end
        end
        WAIT_LOWPWR: begin
          if (intReq) begin
            if (wakeToRun) begin
              nxtMode        = RUN_NORMAL;
              strb.clrRunSel = 1'b1;
            end else begin
              nxtMode = RUN_LOWPWR;
            end
          end
        end
        STOP_LOWPWR: begin
          if (intReq) begin
            if (!fromLp || wakeToRun) begin
              nxtMode        = RUN_NORMAL;
              strb.clrRunSel = fromLp;
            end else begin
              nxtMode = RUN_LOWPWR;
            end
          end
        end
        default: begin
          if (intReq) nxtMode = fromLp ? RUN_LOWPWR : RUN_NORMAL;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode    <= RUN_NORMAL;
      target     <= RUN_NORMAL;
      fromLp     <= 1'b0;
      entering   <= 1'b0;
      cnt        <= '0;
      statusWord <= modeBits(RUN_NORMAL);
    end else begin
      curMode <= nxtMode;
      if (startEntry) begin
        entering <= 1'b1;
        cnt      <= CNT_W'(ENTRY_CYC);
        fromLp   <= (curMode == RUN_LOWPWR);
        target   <= stopTarget(stopSel, curMode == RUN_LOWPWR);
      end else if (entering) begin
        if (abortNow || cnt == CNT_W'(1)) entering <= 1'b0;
        else cnt <= cnt - CNT_W'(1);
      end
      if (!(dbgEn && (nxtMode == STOP_NORMAL || nxtMode == STOP_LOWPWR)))
        statusWord <= modeBits(nxtMode);
    end
  end

endmodule

// File: rtl/pwrModeCtl.sv
module pwrModeCtl
  import pmc_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              sleepReq,
  input  logic              deepSleep,
  input  logic              intReq,
  input  logic              entryRst,
  input  logic              dbgEn,
  output logic [MODE_N-1:0] modeOneHot,
  output logic              stopAborted
);

  seqStrobe_t        strb;
  logic [MODE_N-1:0] statusWord;
  logic              permLp;
  logic              permLl;
  logic              permDeep;
  logic [2:0]        stopSel;
  logic [1:0]        runSel;
  logic              wakeToRun;
  logic              abortFlag;
  logic              seqInEntry;

  pmcRegs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strb(strb),
    .statusWord(statusWord), .permLp(permLp), .permLl(permLl),
    .permDeep(permDeep), .stopSel(stopSel), .runSel(runSel),
    .wakeToRun(wakeToRun), .abortFlag(abortFlag)
  );

  pmcSeq #(.ENTRY_CYC(ENTRY_CYC)) seq_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .deepSleep(deepSleep),
    .intReq(intReq), .entryRst(entryRst), .dbgEn(dbgEn),
    .stopSel(stopSel), .runSel(runSel), .wakeToRun(wakeToRun),
    .strb(strb), .statusWord(statusWord), .inEntry(seqInEntry)
  );

  assign modeOneHot  = statusWord;
  assign stopAborted = abortFlag;

endmodule

// File: rtl/pwrModeCtl_chk.sv
module pwrModeCtl_chk
  import pmc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [MODE_N-1:0] modeOneHot,
  input logic              stopAborted,
  input logic              dbgEn,
  input logic              inEntry,
  input logic              permLp,
  input logic              permLl
);

  assert_status_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(modeOneHot) == 1);

  assert_abort_holds_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopAborted) |-> $stable(modeOneHot));

  assert_stop_after_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(modeOneHot[STOP_LOWPWR]) || $rose(modeOneHot[STOP_LOWLEAK]) ||
     $rose(modeOneHot[STOP_DEEP])) |-> $past(inEntry));

  assert_lprun_permitted_R4: assert property (@(posedge clk) disable iff (!rstN)
    modeOneHot[RUN_LOWPWR] |-> permLp);

  assert_leak_permitted_R3: assert property (@(posedge clk) disable iff (!rstN)
    modeOneHot[STOP_LOWLEAK] |-> permLl);

  assert_debug_hides_stop_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeOneHot[STOP_NORMAL]) |-> !$past(dbgEn));

endmodule

bind pwrModeCtl pwrModeCtl_chk chk_i (
  .clk(clk), .rstN(rstN), .modeOneHot(modeOneHot), .stopAborted(stopAborted),
  .dbgEn(dbgEn), .inEntry(seqInEntry), .permLp(permLp), .permLl(permLl)
);

// File: tb/pwrModeCtl_tb_top.sv
`timescale 1ns/1ps
module pwrModeCtl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       sleepReq = 1'b0;
  logic       deepSleep = 1'b0;
  logic       intReq = 1'b0;
  logic       entryRst = 1'b0;
  logic       dbgEn = 1'b0;
  logic [6:0] modeOneHot;
  logic       stopAborted;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwrModeCtl dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sleepReq(sleepReq),
    .deepSleep(deepSleep), .intReq(intReq), .entryRst(entryRst),
    .dbgEn(dbgEn), .modeOneHot(modeOneHot), .stopAborted(stopAborted)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    busAddr = a;
    #0.5;
    v = busRdata;
  endtask

  task automatic chkReg(string req, logic [1:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic sleepPulse(logic deep);
    sleepReq = 1'b1; deepSleep = deep;
    @(negedge clk);
    sleepReq = 1'b0; deepSleep = 1'b0;
  endtask

  task automatic intPulse();
    intReq = 1'b1;
    @(negedge clk);
    intReq = 1'b0;
  endtask

  function automatic logic [7:0] expDeep(logic [7:0] old, logic [7:0] w);
    logic [2:0] sub;
    sub = w[2] ? old[2:0] : w[2:0];
    return {2'b00, w[5], 2'b00, sub};
  endfunction

  function automatic logic [2:0] expStop(logic [2:0] old, logic [2:0] w);
    return (w == 3'b000 || w == 3'b010 || w == 3'b011 || w == 3'b100) ? w : old;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] deepModel;
    logic [2:0] stopModel;
    void'($urandom(32'd1234));
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    chkReg("R1 perm", 2'd0, 8'h00);
    chkReg("R1 ctrl", 2'd1, 8'h00);
    chkReg("R1 deep", 2'd2, 8'h03);
    chkReg("R1 status", 2'd3, 8'h01);
    chk("R1 port mode", modeOneHot, 7'h01);
    chk("R1 abort", stopAborted, 1'b0);

    // R3/R4 without permission
    wr(2'd1, 8'h03);
    chkReg("R3 leak stop blocked", 2'd1, 8'h00);
    wr(2'd1, 8'h40);
    tick(1);
    chkReg("R4 lp run blocked", 2'd1, 8'h00);
    chk("R4 stays run", modeOneHot, 7'h01);

    // R2 write-once permission
    wr(2'd0, 8'hFF);
    chkReg("R2 masked perm", 2'd0, 8'h2A);
    wr(2'd0, 8'h00);
    chkReg("R2 second write ignored", 2'd0, 8'h2A);

    // R3 stop select encodings
    wr(2'd1, 8'h03);
    chkReg("R3 leak accepted", 2'd1, 8'h03);
    wr(2'd1, 8'h01);
    chkReg("R3 reserved 001", 2'd1, 8'h03);
    wr(2'd1, 8'h07);
    chkReg("R3 reserved 111", 2'd1, 8'h03);

    // R7 leakage-reduced stop entry timing
    sleepPulse(1'b1);
    chk("R7 entry cycle0 still run", modeOneHot, 7'h01);
    tick(1);
    chk("R7 entry cycle1 still run", modeOneHot, 7'h01);
    tick(1);
    chk("R7 leak stop entered", modeOneHot, 7'h20);
    chkReg("R6 status reg leak", 2'd3, 8'h20);
    intPulse();
    chk("R9 leak exit to run", modeOneHot, 7'h01);

    // R8 abort by interrupt
    sleepPulse(1'b1);
    intReq = 1'b1;
    tick(1);
    intReq = 1'b0;
    chk("R8 abort flag", stopAborted, 1'b1);
    chkReg("R8 abort in ctrl bit3", 2'd1, 8'h0B);
    tick(2);
    chk("R8 mode unchanged", modeOneHot, 7'h01);
    sleepPulse(1'b1);
    chk("R7 abort cleared at entry", stopAborted, 1'b0);
    tick(2);
    chk("R7 leak after clean entry", modeOneHot, 7'h20);
    intPulse();

    // R8 abort by entry reset in second cycle
    sleepPulse(1'b1);
    tick(1);
    entryRst = 1'b1;
    tick(1);
    entryRst = 1'b0;
    chk("R8 entry reset abort", stopAborted, 1'b1);
    chk("R8 entry reset mode", modeOneHot, 7'h01);

    // R7 deep stop
    wr(2'd1, 8'h04);
    sleepPulse(1'b1);
    tick(2);
    chk("R7 deep stop", modeOneHot, 7'h40);
    intPulse();
    chk("R9 deep exit", modeOneHot, 7'h01);

    // R12 debug hides normal stop
    wr(2'd1, 8'h00);
    dbgEn = 1'b1;
    sleepPulse(1'b1);
    tick(2);
    chk("R12 debug status held", modeOneHot, 7'h01);
    intPulse();
    dbgEn = 1'b0;
    sleepPulse(1'b1);
    tick(2);
    chk("R7 normal stop", modeOneHot, 7'h02);
    intPulse();
    chk("R9 normal stop exit", modeOneHot, 7'h01);

    // R6 status read-only
    wr(2'd3, 8'h55);
    chkReg("R6 status write ignored", 2'd3, 8'h01);

    // R4 run select
    wr(2'd1, 8'h42);
    wr(2'd1, 8'h02);
    chkReg("R4 early return blocked", 2'd1, 8'h42);
    chk("R4 lp run entered", modeOneHot, 7'h04);
    wr(2'd1, 8'h22);
    chkReg("R4 reserved run code", 2'd1, 8'h42);

    // R11 low-power wait
    sleepPulse(1'b0);
    chk("R11 lp wait", modeOneHot, 7'h08);
    intPulse();
    chk("R11 wait exit to lp run", modeOneHot, 7'h04);

    // R7/R9 low-power stop from low-power run
    sleepPulse(1'b1);
    tick(2);
    chk("R7 lp stop from lp run", modeOneHot, 7'h10);
    intPulse();
    chk("R9 lp stop back to lp run", modeOneHot, 7'h04);

    wr(2'd1, 8'h02);
    tick(1);
    chk("R4 return to run", modeOneHot, 7'h01);

    // R9 low-power stop from normal run
    sleepPulse(1'b1);
    tick(2);
    chk("R9 lp stop from run", modeOneHot, 7'h10);
    intPulse();
    chk("R9 lp stop exits to run", modeOneHot, 7'h01);

    // R10 wake-to-run
    wr(2'd1, 8'h82);
    chkReg("R10 enable set in run", 2'd1, 8'h82);
    wr(2'd1, 8'hC2);
    tick(1);
    chk("R10 lp run", modeOneHot, 7'h04);
    wr(2'd1, 8'h42);
    chkReg("R10 enable locked outside run", 2'd1, 8'hC2);
    intPulse();
    chk("R10 int in lp run to run", modeOneHot, 7'h01);
    chkReg("R10 run select cleared", 2'd1, 8'h82);
    tick(1);
    chk("R10 stays run", modeOneHot, 7'h01);
    wr(2'd1, 8'hC2);
    tick(1);
    sleepPulse(1'b0);
    chk("R11 wait with wake enable", modeOneHot, 7'h08);
    intPulse();
    chk("R10 wait to run", modeOneHot, 7'h01);
    chkReg("R10 run select cleared wait", 2'd1, 8'h82);
    wr(2'd1, 8'hC2);
    tick(1);
    sleepPulse(1'b1);
    tick(2);
    chk("R10 lp stop entered", modeOneHot, 7'h10);
    intPulse();
    chk("R10 lp stop to run", modeOneHot, 7'h01);
    chkReg("R10 run select cleared stop", 2'd1, 8'h82);
    wr(2'd1, 8'h02);

    // R5 directed and random deep-stop writes
    wr(2'd2, 8'h22);
    chkReg("R5 sub2 por off", 2'd2, 8'h22);
    wr(2'd2, 8'h05);
    chkReg("R5 reserved sub", 2'd2, 8'h02);
    deepModel = 8'h02;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] w;
      w = 8'($urandom);
      wr(2'd2, w);
      deepModel = expDeep(deepModel, w);
      chkReg("R5 random deep write", 2'd2, deepModel);
    end

    // R3/R10 random stop select and wake enable while in run
    stopModel = 3'b010;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] w;
      w = 8'($urandom) & 8'h8F;
      wr(2'd1, w);
      stopModel = expStop(stopModel, w[2:0]);
      chkReg("R3 random stop select", 2'd1, {w[7], 4'b0000, stopModel});
    end
    chk("R4 random keeps run", modeOneHot, 7'h01);

    finishRun();
  end

endmodule